// File: doc/BRIEF.md
# Sticky Serial Balance Detector

This block watches a serial stream, taking one bit on each clock in which the input is valid. It tracks how far the number of zeros seen so far is ahead of, or behind, the number of ones. A zero followed by a one, or a one followed by a zero, leaves the balance unchanged. While the difference stays within one in either direction, the two-bit result reads 00.

The first time zeros lead by two, the result changes to 10. The first time ones lead by two, it changes to 01. Either result then stays fixed until a reset. Later bits have no effect, even if they would bring the counts level again. The machine has five states: three tracking states (ones ahead by one, level, zeros ahead by one) and two locked states.

The output is Mealy style. The bit that completes the lead of two shows its locked code in the same cycle it is presented. The input side is a valid/ready port. Ready is always high, so the block applies no back-pressure and consumes every valid bit in the cycle it is presented.

Top module: `sticky_balance_det`

## Requirements
- R1: A synchronous active-high reset puts the machine in the level state. With valid low after reset, the result reads 00.
- R2: The result reads 00 while the zero/one difference over all accepted bits stays within one, so alternating bits never lock.
- R3: When an accepted bit makes zeros lead ones by two, the result reads 10 (bit 1 set) in that same cycle.
- R4: When an accepted bit makes ones lead zeros by two, the result reads 01 (bit 0 set) in that same cycle.
- R5: Once locked, the result keeps its locked code on every later cycle until reset, whatever bits arrive. Only a reset clears a locked state.
- R6: A cycle with valid low changes nothing. The state holds, and the result shows the current state's code.
- R7: The result never reads 11.
- R8: Ready is high in every cycle, so every bit presented with valid high is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Serial bit is present this cycle |
| in_ready | output | 1 | Block accepts a bit (always high) |
| in_bit | input | 1 | Serial data bit |
| result | output | 2 | 00 tracking, 10 zeros locked, 01 ones locked |

## Verification
The hardest case to reach is a locked machine that then receives bits which would balance the counts again. Only that case shows the lock is truly absorbing and not recomputed from a counter. The stimulus first locks on zeros. It then sends a long run of ones, enough to bring the counts level and past level, and checks that the result stays 10. The same pattern runs with the roles swapped. Valid-low gaps are mixed in just before a lock, to show that a withheld bit does not complete the lead.

// File: rtl/balance_pkg.sv
package balance_pkg;
  localparam int RES_W = 2;

  typedef enum logic [2:0] {
    ST_ONES1 = 3'd0,
    ST_LEVEL = 3'd1,
    ST_ZERO1 = 3'd2,
    ST_LOCKZ = 3'd3,
    ST_LOCKO = 3'd4
  } bal_state_t;

  localparam logic [RES_W-1:0] RES_NONE  = 2'b00;
  localparam logic [RES_W-1:0] RES_ZEROS = 2'b10;
  localparam logic [RES_W-1:0] RES_ONES  = 2'b01;
endpackage

// File: rtl/balance_step.sv
module balance_step
  import balance_pkg::*;
(
  input  bal_state_t cur,
  input  logic       take,
  input  logic       bit_in,
  output bal_state_t nxt
);
  always_comb begin
    nxt = cur;
    if (take) begin
      unique case (cur)
        ST_ONES1: nxt = bit_in ? ST_LOCKO : ST_LEVEL;
        ST_LEVEL: nxt = bit_in ? ST_ONES1 : ST_ZERO1;
        ST_ZERO1: nxt = bit_in ? ST_LEVEL : ST_LOCKZ;
        ST_LOCKZ: nxt = ST_LOCKZ;
        ST_LOCKO: nxt = ST_LOCKO;
        default:  nxt = ST_LEVEL;
      endcase
    end
  end
endmodule

// File: rtl/balance_code.sv
module balance_code
  import balance_pkg::*;
(
  input  bal_state_t       st,
  output logic [RES_W-1:0] code
);
  always_comb begin
    unique case (st)
      ST_LOCKZ: code = RES_ZEROS;
      ST_LOCKO: code = RES_ONES;
      default:  code = RES_NONE;
    endcase
  end
endmodule

// File: rtl/sticky_balance_det.sv
module sticky_balance_det
  import balance_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic [RES_W-1:0] result
);
  bal_state_t state_q;
  bal_state_t state_d;
  logic       take;

  assign in_ready = 1'b1;
  assign take     = in_valid & in_ready;

  balance_step u_step (
    .cur    (state_q),
    .take   (take),
    .bit_in (in_bit),
    .nxt    (state_d)
  );

  // Mealy: the result follows the state that this cycle's bit leads to
  balance_code u_code (
    .st   (state_d),
    .code (result)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_LEVEL;
    else     state_q <= state_d;
  end

  assert_reset_level_R1: assert property (@(posedge clk)
    rst |=> (state_q == ST_LEVEL));

  assert_tracking_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_LEVEL) || (!in_valid && (state_q != ST_LOCKZ) && (state_q != ST_LOCKO)))
      |-> (result == RES_NONE));

  assert_zero_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ZERO1 && in_valid && !in_bit) |-> (result == RES_ZEROS));

  assert_one_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ONES1 && in_valid && in_bit) |-> (result == RES_ONES));

  assert_lockz_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCKZ) |=> (state_q == ST_LOCKZ && result == RES_ZEROS));

  assert_locko_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCKO) |=> (state_q == ST_LOCKO && result == RES_ONES));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(state_q));

  assert_no_both_R7: assert property (@(posedge clk) disable iff (rst)
    result != 2'b11);
endmodule

// File: tb/sticky_balance_det_tb.sv
`timescale 1ns/1ps
module sticky_balance_det_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_ready;
  logic [1:0] result;

  int checks = 0;
  int errors = 0;
  int diff = 0;          // zeros minus ones, model
  logic [1:0] lockc = 2'b00;

  always #2.5 clk = ~clk;

  sticky_balance_det u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .result(result)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: result=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    diff = 0; lockc = 2'b00;
    #1;
    check("R1", result, 2'b00);
  endtask

  // present one cycle of input, check the Mealy result before the edge
  task automatic step(input logic v, input logic b, input string req);
    logic [1:0] exp;
    @(negedge clk);
    in_valid = v; in_bit = b;
    if (v && lockc == 2'b00) begin
      diff = b ? diff - 1 : diff + 1;
      if (diff == 2)  lockc = 2'b10;
      if (diff == -2) lockc = 2'b01;
    end
    exp = lockc;
    #1;
    check(req, result, exp);
    check("R7", {1'b0, result == 2'b11}, 2'b00);
    check("R8", {1'b0, in_ready}, 2'b01);
  endtask

  task automatic t_zero_lock();
    do_reset();
    step(1, 0, "R2"); step(1, 1, "R2"); step(1, 0, "R2");
    step(1, 0, "R3");
    step(1, 1, "R5"); step(1, 1, "R5"); step(1, 1, "R5"); step(1, 1, "R5");
    step(0, 0, "R5");
  endtask

  task automatic t_one_lock();
    do_reset();
    step(1, 1, "R2"); step(1, 0, "R2"); step(1, 1, "R2");
    step(1, 1, "R4");
    step(1, 0, "R5"); step(1, 0, "R5"); step(1, 0, "R5"); step(1, 0, "R5");
  endtask

  task automatic t_cancel();
    do_reset();
    for (int i = 0; i < 12; i++) step(1, i[0], "R2");
    for (int i = 0; i < 12; i++) step(1, ~i[0], "R2");
  endtask

  task automatic t_valid_gap();
    do_reset();
    step(1, 0, "R6");
    step(0, 0, "R6"); step(0, 0, "R6"); step(0, 0, "R6");
    step(1, 1, "R6");
    step(1, 1, "R6");
    step(0, 1, "R6"); step(0, 1, "R6");
    step(1, 1, "R4");
  endtask

  task automatic t_reset_clears();
    do_reset();
    step(1, 0, "R3"); step(1, 0, "R3");
    do_reset();
    step(1, 1, "R1"); step(1, 1, "R4");
    do_reset();
    step(0, 0, "R1");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: result=%b expected=done", result);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_zero_lock();
    t_one_lock();
    t_cancel();
    t_valid_gap();
    t_reset_clears();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule